// File: doc/BRIEF.md
# Display Sleep and Wake Controller

This block governs the low-power state of a display refresh engine. It holds a control word (sleep, auto-sleep enable, backlight enable, blanking, dot-clock divider), a frame-count inactivity timeout and a backlight brightness value. While the display is awake and auto-sleep is enabled, it counts frame-end strobes that pass with no display-load request and no keyboard or pointer power request, and puts the display to sleep once the programmed number of frames has gone by. A power request wakes the display at once without host action; the host may also enter or leave sleep by writing the sleep bit.

A display-load request that arrives while asleep cannot be served, so the block records it as a missed load and turns blanking on. When the display next wakes with a missed load pending, blanking is forced on and the interrupt output is held high for exactly one scan line, measured between line-end strobes, so that the host can redraw the frame and then clear blanking. The panel-enable, memory self-refresh request, backlight, backlight PWM and dot-clock enable outputs follow the state. The pixel pipeline, memory controller and panel timing generator are outside the block and are represented by the frame-end and line-end strobes.

Top module: `dslp_top`

## Requirements
- R1: After reset the control word reads 0, `panel_en` is 1, `self_refresh_req` is 0, `backlight_on` is 0 and `irq` is 0; the timeout register is 0.
- R2: A register write with `reg_addr`=0 and bit 1 of the data set enters sleep on the next clock edge (`panel_en` 0, `self_refresh_req` 1); a write with bit 1 clear leaves sleep.
- R3: `pwr_req` high on a clock edge clears the sleep bit on that edge, even when a host write setting the sleep bit happens on the same edge.
- R4: With auto-sleep (control bit 2) set and the timeout register (`reg_addr`=1) holding N ≥ 1, the sleep bit becomes 1 on the edge of the Nth frame-end strobe with no activity; a timeout of 0 never causes auto-sleep.
- R5: `disp_load` high or `pwr_req` high on an edge restarts the inactivity count at N, so N further quiet frames are needed.
- R6: With auto-sleep clear, no number of frame-end strobes changes the sleep bit.
- R7: `disp_load` high while asleep sets the blanking bit (control bit 4) and records a missed load; `irq` stays 0 while asleep.
- R8: On leaving sleep with a missed load pending the blanking bit is 1; `irq` rises on the edge of the first line-end strobe after the wake and falls on the edge of the next one; a later wake with no new missed load gives no pulse.
- R9: `backlight_on` equals backlight enable (control bit 3) AND not asleep; while it is 1, `bright_pwm` is high for exactly B of every 256 cycles, B being the 8-bit brightness register (`reg_addr`=2); otherwise `bright_pwm` is 0.
- R10: `dot_clk_en` pulses once every D+1 clock cycles, D being the divider field (control bits 11:9).
- R11: The control word reads back with sleep at bit 1, auto-sleep at bit 2, backlight enable at bit 3, blanking at bit 4, divider at bits 11:9, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 timeout, 2 brightness |
| reg_wdata | input | 16 | Write data |
| ctrl_rd | output | 16 | Current control word |
| frame_end | input | 1 | One-cycle strobe at the end of each output frame |
| line_end | input | 1 | One-cycle strobe at the end of each scan line |
| disp_load | input | 1 | Display-load request, level |
| pwr_req | input | 1 | Keyboard or pointer power request |
| panel_en | output | 1 | Panel power enable, low while asleep |
| self_refresh_req | output | 1 | Frame memory self-refresh request, high while asleep |
| blank_out | output | 1 | Show black instead of frame memory |
| backlight_on | output | 1 | Backlight enable pin |
| bright_pwm | output | 1 | Backlight brightness PWM |
| dot_clk_en | output | 1 | Dot clock enable pulse |
| irq | output | 1 | Missed-load interrupt, one scan line long |

## Verification
A wrong inactivity count shows at the ports as the sleep bit and `panel_en` changing one or more frame strobes early or late, or never, so each timeout trial checks the frame just before and exactly at the expected edge. A lost or stale missed-load flag shows as a missing or extra `irq` pulse at the first line-end after a wake, and a wrong blanking state is visible on the control readback on the very edge of the wake. PWM and divider faults appear within one 256-cycle period or one divider interval as a wrong high count or pulse spacing.

// File: rtl/dslp_pkg.sv
package dslp_pkg;

    localparam int DIV_W  = 3;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_TMO  = 2'd1,
        ADDR_BRT  = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             blank;
        logic             bl_en;
        logic             auto_en;
        logic             sleep;
    } ctrl_t;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_WAIT = 2'd1,
        IRQ_ACT  = 2'd2
    } irq_st_e;

    function automatic logic [WORD_W-1:0] ctrl_pack(ctrl_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[1]     = c.sleep;
        w[2]     = c.auto_en;
        w[3]     = c.bl_en;
        w[4]     = c.blank;
        w[11:9]  = c.div;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [WORD_W-1:0] w);
        ctrl_t c;
        c.sleep   = w[1];
        c.auto_en = w[2];
        c.bl_en   = w[3];
        c.blank   = w[4];
        c.div     = w[11:9];
        return c;
    endfunction

endpackage

// File: rtl/dslp_core.sv
module dslp_core
    import dslp_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  ctrl_t            ctrl_wdata,
    input  logic             tmo_we,
    input  logic [TMO_W-1:0] tmo_wdata,
    input  logic             frame_end,
    input  logic             line_end,
    input  logic             disp_load,
    input  logic             pwr_req,
    output ctrl_t            ctrl_o,
    output logic             irq_o
);

    ctrl_t            ctrl_q, ctrl_d;
    logic [TMO_W-1:0] tmo_q, cnt_q, cnt_d;
    logic             missed_q, missed_d;
    irq_st_e          st_q, st_d;
    logic             activity, auto_fire, missed_set, pulse_done, wake;

    always_comb begin
        activity   = disp_load | pwr_req;
        auto_fire  = ctrl_q.auto_en & ~ctrl_q.sleep & frame_end & ~activity
                     & (cnt_q == TMO_W'(1));
        missed_set = ctrl_q.sleep & disp_load;
        pulse_done = (st_q == IRQ_ACT) & line_end;

        ctrl_d = ctrl_q;
        if (ctrl_we)    ctrl_d = ctrl_wdata;
        if (auto_fire)  ctrl_d.sleep = 1'b1;
        if (pwr_req)    ctrl_d.sleep = 1'b0;
        if (missed_set) ctrl_d.blank = 1'b1;

        missed_d = (missed_q & ~pulse_done) | missed_set;
        wake     = ctrl_q.sleep & ~ctrl_d.sleep;
        if (wake & missed_d) ctrl_d.blank = 1'b1;

        st_d = st_q;
        case (st_q)
            IRQ_IDLE: if (wake & missed_d) st_d = IRQ_WAIT;
            IRQ_WAIT: if (line_end)        st_d = IRQ_ACT;
            IRQ_ACT:  if (line_end)        st_d = IRQ_IDLE;
            default:                       st_d = IRQ_IDLE;
        endcase

        if (tmo_we)
            cnt_d = tmo_wdata;
        else if (activity | ctrl_q.sleep | ~ctrl_q.auto_en | auto_fire)
            cnt_d = tmo_q;
        else if (frame_end && cnt_q != '0)
            cnt_d = cnt_q - TMO_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            tmo_q    <= '0;
            cnt_q    <= '0;
            missed_q <= 1'b0;
            st_q     <= IRQ_IDLE;
        end else begin
            ctrl_q   <= ctrl_d;
            cnt_q    <= cnt_d;
            missed_q <= missed_d;
            st_q     <= st_d;
            if (tmo_we) tmo_q <= tmo_wdata;
        end
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = (st_q == IRQ_ACT);

    p_pwr_wakes_r3: assert property (@(posedge clk) disable iff (rst)
        pwr_req |=> !ctrl_o.sleep);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= tmo_q);

    p_no_auto_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.auto_en && !ctrl_we && !ctrl_q.sleep) |=> !ctrl_o.sleep);

    p_missed_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o.sleep && disp_load) |=> ctrl_o.blank);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !line_end) |=> irq_o);

    p_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && line_end) |=> !irq_o);

endmodule

// File: rtl/dslp_pwm.sv
module dslp_pwm #(
    parameter int BRT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [BRT_W-1:0] level_i,
    output logic             pwm_o
);

    logic [BRT_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + BRT_W'(1);
    end

    assign pwm_o = en_i & (phase_q < level_i);

endmodule

// File: rtl/dslp_dotdiv.sv
module dslp_dotdiv
    import dslp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             ce_o
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (ce_o) cnt_q <= '0;
        else           cnt_q <= cnt_q + DIV_W'(1);
    end

    assign ce_o = (cnt_q == div_i);

    p_ce_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (ce_o && div_i != '0) |=> (!ce_o || !$stable(div_i)));

endmodule

// File: rtl/dslp_top.sv
module dslp_top
    import dslp_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int BRT_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] ctrl_rd,
    input  logic        frame_end,
    input  logic        line_end,
    input  logic        disp_load,
    input  logic        pwr_req,
    output logic        panel_en,
    output logic        self_refresh_req,
    output logic        blank_out,
    output logic        backlight_on,
    output logic        bright_pwm,
    output logic        dot_clk_en,
    output logic        irq
);

    ctrl_t            ctrl;
    logic             ctrl_we, tmo_we, brt_we;
    logic [BRT_W-1:0] brt_q;
    logic             unused_wdata_bits;

    assign ctrl_we = reg_we & (reg_addr == ADDR_CTRL);
    assign tmo_we  = reg_we & (reg_addr == ADDR_TMO);
    assign brt_we  = reg_we & (reg_addr == ADDR_BRT);
    assign unused_wdata_bits = ^reg_wdata[WORD_W-1:BRT_W];

    always_ff @(posedge clk) begin
        if (rst)         brt_q <= '0;
        else if (brt_we) brt_q <= reg_wdata[BRT_W-1:0];
    end

    dslp_core #(.TMO_W(TMO_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_unpack(reg_wdata)),
        .tmo_we     (tmo_we),
        .tmo_wdata  (reg_wdata[TMO_W-1:0]),
        .frame_end  (frame_end),
        .line_end   (line_end),
        .disp_load  (disp_load),
        .pwr_req    (pwr_req),
        .ctrl_o     (ctrl),
        .irq_o      (irq)
    );

    dslp_pwm #(.BRT_W(BRT_W)) u_pwm (
        .clk     (clk),
        .rst     (rst),
        .en_i    (backlight_on),
        .level_i (brt_q),
        .pwm_o   (bright_pwm)
    );

    dslp_dotdiv u_div (
        .clk   (clk),
        .rst   (rst),
        .div_i (ctrl.div),
        .ce_o  (dot_clk_en)
    );

    assign ctrl_rd          = ctrl_pack(ctrl);
    assign panel_en         = ~ctrl.sleep;
    assign self_refresh_req = ctrl.sleep;
    assign blank_out        = ctrl.blank;
    assign backlight_on     = ctrl.bl_en & ~ctrl.sleep;

endmodule

// File: tb/dslp_top_tb.sv
`timescale 1ns/1ps
module dslp_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ctrl_rd;
    logic        frame_end = 1'b0, line_end = 1'b0, disp_load = 1'b0, pwr_req = 1'b0;
    logic        panel_en, self_refresh_req, blank_out, backlight_on, bright_pwm, dot_clk_en, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dslp_top u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ctrl_rd(ctrl_rd), .frame_end(frame_end), .line_end(line_end), .disp_load(disp_load),
        .pwr_req(pwr_req), .panel_en(panel_en), .self_refresh_req(self_refresh_req),
        .blank_out(blank_out), .backlight_on(backlight_on), .bright_pwm(bright_pwm),
        .dot_clk_en(dot_clk_en), .irq(irq)
    );

    function automatic logic [15:0] exp_ctrl(logic [15:0] d);
        return d & 16'h0E1E;
    endfunction

    function automatic int exp_pwm_high(int b);
        return b;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic frame_pulse();
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0; step(2);
    endtask

    task automatic line_pulse();
        line_end = 1'b1; @(negedge clk); line_end = 1'b0;
    endtask

    task automatic pwr_pulse();
        pwr_req = 1'b1; @(negedge clk); pwr_req = 1'b0;
    endtask

    task automatic load_pulse();
        disp_load = 1'b1; @(negedge clk); disp_load = 1'b0;
    endtask

    initial begin
        #900000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        step(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctrl", ctrl_rd, 16'h0);
        chk("R1 panel_en", panel_en, 1);
        chk("R1 self_refresh", self_refresh_req, 0);
        chk("R1 backlight", backlight_on, 0);
        chk("R1 irq", irq, 0);
        for (int i = 0; i < 6; i++) frame_pulse();
        wr(2'd0, 16'h0004);
        for (int i = 0; i < 6; i++) frame_pulse();
        chk("R1 timeout zero, no auto sleep", ctrl_rd[1], 0);

        // R11 layout
        wr(2'd0, 16'hFFFF);
        chk("R11 readback all ones", ctrl_rd, exp_ctrl(16'hFFFF));
        wr(2'd0, 16'h0A14);
        chk("R11 readback pattern", ctrl_rd, exp_ctrl(16'h0A14));
        wr(2'd0, 16'h0000);

        // R2 host sleep/wake
        wr(2'd0, 16'h0002);
        chk("R2 sleep bit", ctrl_rd[1], 1);
        chk("R2 panel_en low", panel_en, 0);
        chk("R2 self refresh high", self_refresh_req, 1);
        wr(2'd0, 16'h0000);
        chk("R2 wake panel_en", panel_en, 1);
        chk("R2 wake self refresh", self_refresh_req, 0);

        // R3 power request wins
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0002; pwr_req = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; pwr_req = 1'b0;
        chk("R3 pwr_req beats write", ctrl_rd[1], 0);
        wr(2'd0, 16'h0002);
        pwr_pulse();
        chk("R3 pwr_req wakes", ctrl_rd[1], 0);
        chk("R3 panel_en", panel_en, 1);

        // R4 auto sleep, random timeouts
        for (int t = 0; t < 5; t++) begin
            int n;
            n = (t == 0) ? 1 : $urandom_range(2, 12);
            wr(2'd1, 16'(n));
            wr(2'd0, 16'h0004);
            for (int f = 0; f < n - 1; f++) frame_pulse();
            chk("R4 awake before timeout", ctrl_rd[1], 0);
            frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
            chk("R4 asleep at timeout", ctrl_rd[1], 1);
            chk("R4 panel off", panel_en, 0);
            wr(2'd0, 16'h0000);
        end

        // R5 activity restarts count
        wr(2'd1, 16'd4);
        wr(2'd0, 16'h0004);
        for (int f = 0; f < 3; f++) frame_pulse();
        load_pulse();
        for (int f = 0; f < 3; f++) frame_pulse();
        chk("R5 disp_load reload", ctrl_rd[1], 0);
        pwr_pulse();
        for (int f = 0; f < 3; f++) frame_pulse();
        chk("R5 pwr_req reload", ctrl_rd[1], 0);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        chk("R5 sleeps after full count", ctrl_rd[1], 1);
        wr(2'd0, 16'h0000);

        // R6 auto disabled
        wr(2'd1, 16'd2);
        for (int f = 0; f < 10; f++) frame_pulse();
        chk("R6 no auto sleep", ctrl_rd[1], 0);

        // R7 / R8 missed load
        wr(2'd0, 16'h0002);
        load_pulse();
        chk("R7 blank set", ctrl_rd[4], 1);
        chk("R7 blank_out", blank_out, 1);
        chk("R7 irq low asleep", irq, 0);
        wr(2'd0, 16'h0002);
        chk("R7 host cleared blank", ctrl_rd[4], 0);
        pwr_pulse();
        chk("R8 awake", ctrl_rd[1], 0);
        chk("R8 blank forced", ctrl_rd[4], 1);
        step(3);
        chk("R8 irq waits for line", irq, 0);
        line_pulse();
        chk("R8 irq rises", irq, 1);
        step(6);
        chk("R8 irq held", irq, 1);
        line_pulse();
        chk("R8 irq falls", irq, 0);
        wr(2'd0, 16'h0002);
        wr(2'd0, 16'h0000);
        line_pulse(); step(2); line_pulse();
        chk("R8 no repeat pulse", irq, 0);

        // R9 backlight and PWM
        wr(2'd0, 16'h0008);
        chk("R9 backlight on", backlight_on, 1);
        for (int t = 0; t < 5; t++) begin
            int b, hi;
            b = (t == 0) ? 0 : (t == 1) ? 255 : $urandom_range(1, 254);
            wr(2'd2, 16'(b));
            hi = 0;
            for (int c = 0; c < 256; c++) begin
                @(negedge clk);
                if (bright_pwm) hi++;
            end
            chk("R9 pwm duty", hi, exp_pwm_high(b));
        end
        wr(2'd2, 16'd200);
        wr(2'd0, 16'h000A);
        chk("R9 backlight off asleep", backlight_on, 0);
        begin
            int hi;
            hi = 0;
            for (int c = 0; c < 256; c++) begin
                @(negedge clk);
                if (bright_pwm) hi++;
            end
            chk("R9 pwm idle asleep", hi, 0);
        end
        wr(2'd0, 16'h0000);

        // R10 dot clock divider
        for (int t = 0; t < 6; t++) begin
            int d, k;
            d = (t == 0) ? 0 : (t == 1) ? 7 : $urandom_range(1, 6);
            wr(2'd0, 16'(d << 9));
            step(10);
            while (!dot_clk_en) @(negedge clk);
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!dot_clk_en);
            chk("R10 dot clock spacing", k, d + 1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule